// File: doc/BRIEF.md
# Decoder Address Match Unit

This block inspects the leading bytes of a packet that has already been validated and decides whether the packet is meant for this decoder. It compares those bytes against a set of configuration values: a short address, a two-byte long address, and a consist address whose top bit requests a direction reversal. An enable selects long addressing. The block reports a primary-match flag, a consist-match flag, the position of the first command byte, a reversal request and a discard indication.

One clock after the packet strobe, the result appears for a single cycle, so a downstream command stage can latch it. Broadcast, short, long and consist addressing are all resolved in the same cycle. When no consist is configured, the consist flag follows the primary flag, so commands that need a consist match still reach a decoder that is not in a consist.

Top module: `dam_addr_match`

## Requirements
- R1: A lead byte of 0x00 is a broadcast. It sets both the primary and the consist flag, and the command index is 1.
- R2: When long addressing is disabled and the lead byte has bit 7 clear and is non-zero, the primary flag is set exactly when the lead byte equals the short address. The command index is 1.
- R3: When long addressing is enabled, a lead byte with bit 7 clear never sets the primary flag, even when it equals the short address.
- R4: A lead byte with bit 7 set starts a two-byte address, and the command index is 2. With long addressing enabled, the primary flag is set exactly when the lead byte equals the stored high byte and the second byte equals the stored low byte.
- R5: With long addressing disabled, a two-byte address sets no flag.
- R6: Only the low 7 bits of the consist register are compared. For a short-form lead byte with a non-zero consist value, the consist flag is set exactly when the lead byte equals those 7 bits zero-extended, whatever bit 7 of the register holds.
- R7: When the low 7 bits of the consist register are zero, the consist is inactive and the consist flag equals the primary flag.
- R8: A two-byte address never sets the consist flag while the consist is active.
- R9: The reversal output is bit 7 of the consist register, and it is gated so that it is high only when the consist flag is set and the primary flag is clear.
- R10: The discard output is high exactly when neither the primary nor the consist flag is set.
- R11: The results are registered. The result-valid output is high for exactly the one cycle after each packet strobe, and all flag outputs are zero while it is low.
- R12: After reset, result-valid and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_stb | input | 1 | Lead bytes valid this cycle |
| lead_byte | input | 8 | First packet byte |
| next_byte | input | 8 | Second packet byte |
| cfg_short | input | 8 | Short address |
| cfg_long_hi | input | 8 | Long address high byte (bit 7 set in use) |
| cfg_long_lo | input | 8 | Long address low byte |
| cfg_consist | input | 8 | Consist address (low 7 bits); bit 7 requests reversal |
| cfg_long_en | input | 1 | Long addressing enable |
| res_valid | output | 1 | Result valid, one cycle |
| hit_primary | output | 1 | Primary match |
| hit_consist | output | 1 | Consist match |
| cmd_index | output | 2 | Index of the first command byte (1 or 2) |
| dir_flip | output | 1 | Apply consist direction reversal |
| discard | output | 1 | No address matched |

## Verification
The bench sweeps every lead byte against both addressing modes and several consist settings. The consist settings include an inactive consist, one that overlaps the short address, and ones with the reversal bit set. Each long-form byte is tried with both a correct and a wrong second byte.

Each corner case targets a specific fault:
- Comparing the consist register's bit 7 would lose matches whenever the reversal bit is set.
- Not falling back to the primary flag would drop every consist-gated command on a decoder outside a consist.
- Letting the short address pass in long mode would accept foreign packets.
- Ignoring the low byte would accept any long address that shares the high byte.
- Ungated reversal would flip direction on packets sent to the primary address.

// File: rtl/dam_pkg.sv
package dam_pkg;

  typedef enum logic [1:0] {
    KIND_BCAST = 2'd0,
    KIND_SHORT = 2'd1,
    KIND_LONG  = 2'd2
  } addr_kind_e;

  localparam int unsigned IDX_W = 2;

endpackage

// File: rtl/dam_kind_decode.sv
module dam_kind_decode #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]        lead,
  output dam_pkg::addr_kind_e kind
);
  function automatic dam_pkg::addr_kind_e classify(input logic [W-1:0] b);
    if (b[W-1])       return dam_pkg::KIND_LONG;
    else if (b == '0) return dam_pkg::KIND_BCAST;
    else              return dam_pkg::KIND_SHORT;
  endfunction

  always_comb kind = classify(lead);
endmodule

// File: rtl/dam_short_cmp.sv
module dam_short_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] lead,
  input  logic [W-1:0] short_addr,
  input  logic [W-1:0] consist_reg,
  input  logic         long_en,
  output logic         short_hit,
  output logic         cons_hit,
  output logic         cons_active
);
  localparam int unsigned CW = W - 1;

  function automatic logic [CW-1:0] consist_part(input logic [W-1:0] r);
    return r[CW-1:0];
  endfunction

  always_comb begin
    short_hit   = !long_en && (lead == short_addr);
    cons_active = (consist_part(consist_reg) != '0);
    cons_hit    = cons_active && (lead == {1'b0, consist_part(consist_reg)});
  end
endmodule

// File: rtl/dam_long_cmp.sv
module dam_long_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] lead,
  input  logic [W-1:0] follow,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic         long_en,
  output logic         long_hit
);
  function automatic logic pair_eq(input logic [W-1:0] a0, input logic [W-1:0] a1,
                                   input logic [W-1:0] b0, input logic [W-1:0] b1);
    return (a0 == b0) && (a1 == b1);
  endfunction

  always_comb long_hit = long_en && pair_eq(lead, follow, hi, lo);
endmodule

// File: rtl/dam_addr_match.sv
module dam_addr_match #(
  parameter int unsigned W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pkt_stb,
  input  logic [W-1:0]              lead_byte,
  input  logic [W-1:0]              next_byte,
  input  logic [W-1:0]              cfg_short,
  input  logic [W-1:0]              cfg_long_hi,
  input  logic [W-1:0]              cfg_long_lo,
  input  logic [W-1:0]              cfg_consist,
  input  logic                      cfg_long_en,
  output logic                      res_valid,
  output logic                      hit_primary,
  output logic                      hit_consist,
  output logic [dam_pkg::IDX_W-1:0] cmd_index,
  output logic                      dir_flip,
  output logic                      discard
);
  import dam_pkg::*;

  addr_kind_e       kind;
  logic             short_hit, cons_hit, cons_active, long_hit;
  logic             nxt_p, nxt_c, nxt_flip, nxt_disc;
  logic [IDX_W-1:0] nxt_idx;

  dam_kind_decode #(.W(W)) u_kind (.lead(lead_byte), .kind(kind));

  dam_short_cmp #(.W(W)) u_short (
    .lead(lead_byte), .short_addr(cfg_short), .consist_reg(cfg_consist),
    .long_en(cfg_long_en), .short_hit(short_hit), .cons_hit(cons_hit),
    .cons_active(cons_active)
  );

  dam_long_cmp #(.W(W)) u_long (
    .lead(lead_byte), .follow(next_byte), .hi(cfg_long_hi), .lo(cfg_long_lo),
    .long_en(cfg_long_en), .long_hit(long_hit)
  );

  always_comb begin
    nxt_p   = 1'b0;
    nxt_c   = 1'b0;
    nxt_idx = IDX_W'(1);
    unique case (kind)
      KIND_BCAST: begin
        nxt_p = 1'b1;
        nxt_c = 1'b1;
      end
      KIND_SHORT: begin
        nxt_p = short_hit;
        nxt_c = cons_active ? cons_hit : short_hit;
      end
      KIND_LONG: begin
        nxt_p   = long_hit;
        nxt_c   = cons_active ? 1'b0 : long_hit;
        nxt_idx = IDX_W'(2);
      end
      default: begin
        nxt_p = 1'b0;
        nxt_c = 1'b0;
      end
    endcase
    nxt_flip = cfg_consist[W-1] && nxt_c && !nxt_p;
    nxt_disc = !(nxt_p || nxt_c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pkt_stb) begin
      res_valid   <= 1'b0;
      hit_primary <= 1'b0;
      hit_consist <= 1'b0;
      cmd_index   <= '0;
      dir_flip    <= 1'b0;
      discard     <= 1'b0;
    end else begin
      res_valid   <= 1'b1;
      hit_primary <= nxt_p;
      hit_consist <= nxt_c;
      cmd_index   <= nxt_idx;
      dir_flip    <= nxt_flip;
      discard     <= nxt_disc;
    end
  end
endmodule

// File: rtl/dam_addr_match_chk.sv
module dam_addr_match_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pkt_stb,
  input logic [W-1:0] lead_byte,
  input logic [W-1:0] cfg_consist,
  input logic         cfg_long_en,
  input logic         res_valid,
  input logic         hit_primary,
  input logic         hit_consist,
  input logic [1:0]   cmd_index,
  input logic         dir_flip,
  input logic         discard
);
  // R1
  a_r1_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_stb && lead_byte == '0 |=> hit_primary && hit_consist && cmd_index == 2'd1);
  // R4
  a_r4_long_index: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_stb && lead_byte[W-1] |=> cmd_index == 2'd2);
  // R5
  a_r5_long_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_stb && lead_byte[W-1] && !cfg_long_en |=> !hit_primary && discard);
  // R8
  a_r8_long_no_consist: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_stb && lead_byte[W-1] && cfg_consist[W-2:0] != '0 |=> !hit_consist);
  // R9
  a_r9_flip_gated: assert property (@(posedge clk) disable iff (!rst_n)
    dir_flip |-> hit_consist && !hit_primary && res_valid);
  // R10
  a_r10_discard_clean: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> !hit_primary && !hit_consist);
  // R11
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(pkt_stb));
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !hit_primary && !hit_consist && !dir_flip && !discard);
endmodule

bind dam_addr_match dam_addr_match_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_stb(pkt_stb), .lead_byte(lead_byte),
  .cfg_consist(cfg_consist), .cfg_long_en(cfg_long_en), .res_valid(res_valid),
  .hit_primary(hit_primary), .hit_consist(hit_consist), .cmd_index(cmd_index),
  .dir_flip(dir_flip), .discard(discard)
);

// File: tb/dam_addr_match_test.sv
module dam_addr_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_stb = 1'b0;
  logic [7:0] lead_byte = '0, next_byte = '0;
  logic [7:0] cfg_short = 8'h03, cfg_long_hi = 8'hC1, cfg_long_lo = 8'h2A;
  logic [7:0] cfg_consist = '0;
  logic       cfg_long_en = 1'b0;
  logic       res_valid, hit_primary, hit_consist, dir_flip, discard;
  logic [1:0] cmd_index;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dam_addr_match uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s lead=%h cons=%h long_en=%0d actual=%0d expected=%0d",
               req, lead_byte, cfg_consist, cfg_long_en, act, exp);
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] cons_set [4];
    cons_set[0] = 8'h00; cons_set[1] = 8'h03; cons_set[2] = 8'h85; cons_set[3] = 8'h83;
    repeat (3) @(negedge clk);
    chk("R12 valid", res_valid, 0);
    chk("R12 flags", {hit_primary, hit_consist, dir_flip, discard}, 0);
    rst_n = 1'b1;
    for (int e = 0; e < 2; e++)
      for (int ci = 0; ci < 4; ci++)
        for (int b = 0; b < 256; b++)
          for (int s = 0; s < 2; s++) begin
            bit ep, ec, ef, longf, act;
            int eidx;
            string rp, rc;
            cfg_long_en = e[0];
            cfg_consist = cons_set[ci];
            lead_byte   = b[7:0];
            next_byte   = cfg_long_lo ^ {7'b0, s[0]};
            pkt_stb     = 1'b1;
            longf = b[7];
            act   = cfg_consist[6:0] != 0;
            if (b == 0) begin
              ep = 1; ec = 1; eidx = 1; rp = "R1"; rc = "R1";
            end else if (longf) begin
              ep = e[0] && b[7:0] == cfg_long_hi && s == 0;
              ec = act ? 1'b0 : ep;
              eidx = 2;
              rp = e[0] ? "R4" : "R5";
              rc = act ? "R8" : "R7";
            end else begin
              ep = !e[0] && b[7:0] == cfg_short;
              ec = act ? (b == int'(cfg_consist & 8'h7F)) : ep;
              eidx = 1;
              rp = e[0] ? "R3" : "R2";
              rc = act ? "R6" : "R7";
            end
            ef = cfg_consist[7] && ec && !ep;
            @(negedge clk);
            pkt_stb = 1'b0;
            chk("R11 valid", res_valid, 1);
            chk(rp, hit_primary, ep);
            chk(rc, hit_consist, ec);
            chk(longf ? "R4 index" : "R1 index", cmd_index, eidx);
            chk("R9", dir_flip, ef);
            chk("R10", discard, !(ep || ec));
            if (b == 255) begin
              @(negedge clk);
              chk("R11 drop", res_valid, 0);
              chk("R11 zero", {hit_primary, hit_consist, dir_flip, discard}, 0);
            end
          end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule